// File: doc/BRIEF.md
# Ramp and Binary-Search Converter Controller

This block is the digital half of a successive-code analog-to-digital converter. An external DAC receives the trial code on `dac_code`. An external comparator returns one bit on `cmp_in`. That bit is 1 while the DAC output is below the unknown input and 0 once the DAC output reaches or passes it.

The controller runs one of two searches, chosen per conversion by `mode` and captured when `start` is accepted:

- **Linear (`mode` = 0).** The code climbs one step at a time from zero. The conversion time therefore grows with the input level.
- **Binary (`mode` = 1).** The code is resolved one bit per test, starting from the top bit. It always takes WIDTH tests.

Each new code is held for a programmable settle time before the comparator is read. The comparator bit is first passed through a synchronizer. At the end of a conversion the block pulses `done`. It then holds the result and the number of comparator tests taken until another conversion is started.

The state machine has three states:

- `ST_IDLE`: waiting for `start`.
- `ST_SETTLE`: counting down the settle time after a new code.
- `ST_TEST`: one cycle in which the synchronized comparator bit is used.

It has these transitions:

- IDLE→SETTLE on an accepted `start`.
- SETTLE→TEST when the settle timer expires.
- TEST→SETTLE when the search continues with a new code.
- TEST→IDLE when the search ends, which also raises `done`.

Top module: `adc_search_ctrl`

## Requirements
- R1: While reset is active, and after it is released with no start, `dac_code`, `busy`, `done`, `result` and `step_count` are all zero.
- R2: `start` is accepted only when `busy` is low, and `busy` is high in the cycle that follows acceptance. A `start` seen while busy has no effect: the running conversion keeps its mode, settle length, result and test count, and raises `done` only once.
- R3: In linear mode (`mode` = 0) the first code driven is 0x0000. After every test in which the comparator reads 1, the code is raised by exactly one.
- R4: A linear conversion ends at the first code for which the comparator reads 0, and that code is the result. If the comparator never reads 0, the search stops at the all-ones code. `step_count` equals result + 1.
- R5: In binary mode (`mode` = 1) the first code is 0x8000, i.e. only the top bit set. Each test clears the trial bit when the comparator reads 0 and keeps it when it reads 1, then sets the next lower bit. The result is therefore the largest code the comparator reported as below the input, or 0 if there is none.
- R6: A binary conversion always takes exactly WIDTH tests (16 by default), whatever the input.
- R7: Each code stays on `dac_code` for `settle_len` + 3 clock cycles before the test that acts on it. This covers the settle count, one timer cycle and two synchronizer stages. `settle_len` is captured at start.
- R8: `done` is high for exactly one cycle, in the first cycle with `busy` low after the final test. `result` and `step_count` keep their values until the next accepted start.
- R9: A `start` presented in the same cycle as `done` is accepted, giving back-to-back conversions with no idle gap.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Request a conversion (taken only when idle) |
| mode | input | 1 | Search select: 0 linear, 1 binary |
| settle_len | input | SETTLE_W (8) | Extra settle cycles per code |
| cmp_in | input | 1 | Comparator bit, 1 = DAC below input |
| dac_code | output | WIDTH (16) | Trial code to the DAC |
| busy | output | 1 | Conversion in progress |
| done | output | 1 | One-cycle end-of-conversion pulse |
| result | output | WIDTH (16) | Converted code |
| step_count | output | WIDTH+1 (17) | Comparator tests used by the last conversion |

## Verification
The `done` pulse of one conversion and the acceptance of the next `start` can occur in the same cycle, because `done` is raised in the first idle cycle. The bench provokes this by issuing every conversion request at the exact falling edge on which it first sees `done`. It judges the outcome in two ways:

- `busy` must be high one cycle later.
- The scoreboard must pop exactly one correct result and test count per request, with no extra or missing `done`.

A request injected during a running conversion, carrying a different mode and settle length, checks the opposite case: the running conversion's scoreboard entry must still match.

// File: rtl/adc_search_pkg.sv
package adc_search_pkg;

    typedef enum logic {
        SRCH_LINEAR = 1'b0,
        SRCH_BINARY = 1'b1
    } search_mode_e;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_SETTLE = 2'd1,
        ST_TEST   = 2'd2
    } ctrl_state_e;

endpackage

// File: rtl/adc_cmp_sync.sv
module adc_cmp_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d_async,
    output logic q_sync
);
    logic [STAGES-1:0] chain_q;

    generate
        if (STAGES == 1) begin : g_single
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain_q <= '0;
                else        chain_q <= d_async;
            end
        end else begin : g_multi
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain_q <= '0;
                else        chain_q <= {chain_q[STAGES-2:0], d_async};
            end
        end
    endgenerate

    assign q_sync = chain_q[STAGES-1];
endmodule

// File: rtl/adc_settle_timer.sv
module adc_settle_timer #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] len,
    output logic             expired
);
    logic [CNT_W:0] count_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)              count_q <= '0;
        else if (load)           count_q <= {1'b0, len} + 1'b1;
        else if (count_q != '0)  count_q <= count_q - 1'b1;
    end

    assign expired = (count_q == '0);
endmodule

// File: rtl/adc_search_ctrl.sv
module adc_search_ctrl
    import adc_search_pkg::*;
#(
    parameter int WIDTH       = 16,
    parameter int SETTLE_W    = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                start,
    input  logic                mode,
    input  logic [SETTLE_W-1:0] settle_len,
    input  logic                cmp_in,
    output logic [WIDTH-1:0]    dac_code,
    output logic                busy,
    output logic                done,
    output logic [WIDTH-1:0]    result,
    output logic [WIDTH:0]      step_count
);
    localparam int               IDX_W    = (WIDTH > 1) ? $clog2(WIDTH) : 1;
    localparam logic [WIDTH-1:0] CODE_MAX = '1;
    localparam logic [WIDTH-1:0] CODE_MSB = {1'b1, {(WIDTH-1){1'b0}}};
    localparam logic [IDX_W-1:0] IDX_TOP  = IDX_W'(WIDTH-1);

    ctrl_state_e         state_q, state_d;
    search_mode_e        mode_q;
    logic [SETTLE_W-1:0] settle_q;
    logic [WIDTH-1:0]    code_q, result_q, bin_next, trial_bit, lower_bit;
    logic [WIDTH:0]      steps_q;
    logic [IDX_W-1:0]    bit_idx_q;
    logic                done_q;
    logic                cmp_s, timer_exp, timer_load, search_end;
    logic                accept;

    adc_cmp_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .d_async (cmp_in),
        .q_sync  (cmp_s)
    );

    adc_settle_timer #(.CNT_W(SETTLE_W)) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (timer_load),
        .len     (accept ? settle_len : settle_q),
        .expired (timer_exp)
    );

    assign accept = (state_q == ST_IDLE) && start;

    // Binary step: drop the trial bit on a low comparator, then arm the next bit down.
    always_comb begin
        trial_bit = {{(WIDTH-1){1'b0}}, 1'b1} << bit_idx_q;
        lower_bit = (bit_idx_q != '0) ? (trial_bit >> 1) : '0;
        bin_next  = (cmp_s ? code_q : (code_q & ~trial_bit)) | lower_bit;
    end

    always_comb begin
        if (mode_q == SRCH_LINEAR) search_end = !cmp_s || (code_q == CODE_MAX);
        else                       search_end = (bit_idx_q == '0);
    end

    assign timer_load = accept || ((state_q == ST_TEST) && !search_end);

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (start)      state_d = ST_SETTLE;
            ST_SETTLE: if (timer_exp)  state_d = ST_TEST;
            ST_TEST:   state_d = search_end ? ST_IDLE : ST_SETTLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Datapath and output registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mode_q    <= SRCH_LINEAR;
            settle_q  <= '0;
            code_q    <= '0;
            result_q  <= '0;
            steps_q   <= '0;
            bit_idx_q <= '0;
            done_q    <= 1'b0;
        end else begin
            done_q <= 1'b0;
            unique case (state_q)
                ST_IDLE: begin
                    if (start) begin
                        mode_q    <= search_mode_e'(mode);
                        settle_q  <= settle_len;
                        code_q    <= mode ? CODE_MSB : '0;
                        bit_idx_q <= IDX_TOP;
                        steps_q   <= '0;
                    end
                end
                ST_SETTLE: begin
                end
                ST_TEST: begin
                    steps_q <= steps_q + 1'b1;
                    if (mode_q == SRCH_LINEAR) begin
                        if (search_end) begin
                            result_q <= code_q;
                            done_q   <= 1'b1;
                        end else begin
                            code_q <= code_q + 1'b1;
                        end
                    end else begin
                        code_q <= bin_next;
                        if (search_end) begin
                            result_q <= bin_next;
                            done_q   <= 1'b1;
                        end else begin
                            bit_idx_q <= bit_idx_q - 1'b1;
                        end
                    end
                end
                default: begin
                end
            endcase
        end
    end

    assign dac_code   = code_q;
    assign busy       = (state_q != ST_IDLE);
    assign done       = done_q;
    assign result     = result_q;
    assign step_count = steps_q;
endmodule

// File: rtl/adc_search_ctrl_chk.sv
module adc_search_ctrl_chk #(
    parameter int WIDTH = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             start,
    input logic             mode,
    input logic             busy,
    input logic             done,
    input logic [WIDTH-1:0] dac_code,
    input logic [WIDTH-1:0] result,
    input logic [WIDTH:0]   step_count,
    input logic             mode_q
);
    localparam logic [WIDTH-1:0] TOP_ONLY = {1'b1, {(WIDTH-1){1'b0}}};

    a_r8_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    a_r8_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);

    a_r8_result_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !start) |=> $stable(result));

    a_r2_mode_held: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> $stable(mode_q));

    a_r3_linear_origin: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy && !mode) |=> (dac_code == '0));

    a_r5_binary_origin: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy && mode) |=> (dac_code == TOP_ONLY));

    a_r6_binary_steps: assert property (@(posedge clk) disable iff (!rst_n)
        (done && mode_q) |-> (step_count == (WIDTH+1)'(WIDTH)));

    a_r4_linear_steps: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !mode_q) |-> (step_count == ({1'b0, result} + 1'b1)));
endmodule

bind adc_search_ctrl adc_search_ctrl_chk #(.WIDTH(WIDTH)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (start),
    .mode       (mode),
    .busy       (busy),
    .done       (done),
    .dac_code   (dac_code),
    .result     (result),
    .step_count (step_count),
    .mode_q     (mode_q)
);

// File: tb/test_adc_search_ctrl.sv
`timescale 1ns/1ps
module test_adc_search_ctrl;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #10 clk = ~clk;

    // 16-bit instance
    logic        start_a = 1'b0, mode_a = 1'b0, cmp_a;
    logic [7:0]  settle_a = 8'd0;
    logic [15:0] dac_a, res_a;
    logic [16:0] steps_a;
    logic        busy_a, done_a;
    logic [31:0] vin_a = 32'd0;
    assign cmp_a = ({16'd0, dac_a} < vin_a);

    adc_search_ctrl i_adc_search_ctrl (
        .clk(clk), .rst_n(rst_n), .start(start_a), .mode(mode_a),
        .settle_len(settle_a), .cmp_in(cmp_a), .dac_code(dac_a),
        .busy(busy_a), .done(done_a), .result(res_a), .step_count(steps_a)
    );

    // 8-bit instance for the saturating linear case
    logic        start_b = 1'b0, mode_b = 1'b0, cmp_b;
    logic [7:0]  settle_b = 8'd0;
    logic [7:0]  dac_b, res_b;
    logic [8:0]  steps_b;
    logic        busy_b, done_b;
    logic [31:0] vin_b = 32'd0;
    assign cmp_b = ({24'd0, dac_b} < vin_b);

    adc_search_ctrl #(.WIDTH(8)) i_adc_search_ctrl_w8 (
        .clk(clk), .rst_n(rst_n), .start(start_b), .mode(mode_b),
        .settle_len(settle_b), .cmp_in(cmp_b), .dac_code(dac_b),
        .busy(busy_b), .done(done_b), .result(res_b), .step_count(steps_b)
    );

    typedef struct {
        int    res;
        int    steps;
        string tag;
    } exp_t;

    exp_t q_a[$];
    exp_t q_b[$];
    int   n_checks = 0;
    int   n_fail   = 0;
    bit   finished = 0;

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // Monitors: pop one expected item per done pulse
    always @(negedge clk) begin
        if (rst_n && done_a) begin
            if (q_a.size() == 0) begin
                check(0, "R2 unexpected done on 16-bit instance", 1, 0);
            end else begin
                exp_t e;
                e = q_a.pop_front();
                check(int'(res_a) == e.res, {e.tag, " result"}, int'(res_a), e.res);
                check(int'(steps_a) == e.steps, {e.tag, " step_count"}, int'(steps_a), e.steps);
            end
        end
        if (rst_n && done_b) begin
            if (q_b.size() == 0) begin
                check(0, "R2 unexpected done on 8-bit instance", 1, 0);
            end else begin
                exp_t e;
                e = q_b.pop_front();
                check(int'(res_b) == e.res, {e.tag, " result"}, int'(res_b), e.res);
                check(int'(steps_b) == e.steps, {e.tag, " step_count"}, int'(steps_b), e.steps);
            end
        end
    end

    task automatic wait_done_a();
        do @(negedge clk); while (!done_a);
    endtask

    task automatic wait_done_b();
        do @(negedge clk); while (!done_b);
    endtask

    // Driver for the 16-bit instance; called at a negedge
    task automatic conv_a(input bit m, input int vin, input int settle,
                          input int er, input int es, input string tag);
        exp_t e;
        vin_a = vin; mode_a = m; settle_a = settle[7:0]; start_a = 1'b1;
        e.res = er; e.steps = es; e.tag = tag;
        q_a.push_back(e);
        @(negedge clk);
        start_a = 1'b0;
        check(busy_a == 1'b1, "R9/R2 start accepted, busy", int'(busy_a), 1);
        wait_done_a();
    endtask

    task automatic conv_b(input bit m, input int vin, input int settle,
                          input int er, input int es, input string tag);
        exp_t e;
        vin_b = vin; mode_b = m; settle_b = settle[7:0]; start_b = 1'b1;
        e.res = er; e.steps = es; e.tag = tag;
        q_b.push_back(e);
        @(negedge clk);
        start_b = 1'b0;
        wait_done_b();
    endtask

    task automatic summary();
        if (!finished) begin
            finished = 1;
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        end
    endtask

    // Watchdog
    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            check(0, "watchdog expired", 0, 1);
            summary();
            $finish;
        end
    end

    initial begin
        // R1: reset state
        repeat (3) @(negedge clk);
        check(dac_a == 16'd0, "R1 dac_code in reset", int'(dac_a), 0);
        check(busy_a == 1'b0, "R1 busy in reset", int'(busy_a), 0);
        check(done_a == 1'b0, "R1 done in reset", int'(done_a), 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        check(res_a == 16'd0, "R1 result after reset", int'(res_a), 0);
        check(steps_a == 17'd0, "R1 step_count after reset", int'(steps_a), 0);
        check(busy_a == 1'b0, "R1 busy after reset", int'(busy_a), 0);

        // R3/R4 linear conversions
        conv_a(1'b0, 0,   0, 0,   1,   "R4 linear vin=0");
        conv_a(1'b0, 5,   1, 5,   6,   "R3 linear vin=5");
        conv_a(1'b0, 300, 2, 300, 301, "R4 linear vin=300");

        // R5/R6 binary conversions, back-to-back (R9)
        conv_a(1'b1, 0,     0, 0,     16, "R5 binary vin=0");
        conv_a(1'b1, 1,     3, 0,     16, "R5 binary vin=1");
        conv_a(1'b1, 40000, 0, 39999, 16, "R6 binary vin=40000");
        conv_a(1'b1, 65536, 1, 65535, 16, "R5 binary full scale");
        conv_a(1'b1, 12345, 0, 12344, 16, "R6 binary vin=12345");
        conv_a(1'b1, 32768, 0, 32767, 16, "R5 binary top bit cleared");

        // R8: result and step_count held while idle
        repeat (6) @(negedge clk);
        check(res_a == 16'd32767, "R8 result held while idle", int'(res_a), 32767);
        check(steps_a == 17'd16, "R8 step_count held while idle", int'(steps_a), 16);
        check(done_a == 1'b0, "R8 done single pulse", int'(done_a), 0);

        // R2: start during a conversion is ignored
        begin
            exp_t e;
            vin_a = 20; mode_a = 1'b0; settle_a = 8'd1; start_a = 1'b1;
            e.res = 20; e.steps = 21; e.tag = "R2 start ignored while busy";
            q_a.push_back(e);
            @(negedge clk);
            start_a = 1'b0;
            repeat (10) @(negedge clk);
            mode_a = 1'b1; settle_a = 8'd0; start_a = 1'b1;
            @(negedge clk);
            start_a = 1'b0;
            check(busy_a == 1'b1, "R2 busy during ignored start", int'(busy_a), 1);
            wait_done_a();
        end
        repeat (20) @(negedge clk);
        check(q_a.size() == 0, "R2 no second done after ignored start", q_a.size(), 0);

        // R7: dwell time per code with settle_len=4
        begin
            exp_t e;
            int gap;
            vin_a = 3; mode_a = 1'b0; settle_a = 8'd4; start_a = 1'b1;
            e.res = 3; e.steps = 4; e.tag = "R7 linear vin=3 settle=4";
            q_a.push_back(e);
            @(negedge clk);
            start_a = 1'b0;
            check(dac_a == 16'd0, "R3 linear first code", int'(dac_a), 0);
            while (dac_a != 16'd1) @(negedge clk);
            gap = 0;
            while (dac_a == 16'd1) begin
                @(negedge clk);
                gap++;
            end
            check(gap == 7, "R7 cycles per code", gap, 7);
            check(dac_a == 16'd2, "R3 code steps by one", int'(dac_a), 2);
            wait_done_a();
        end

        // R5: first binary code
        begin
            exp_t e;
            vin_a = 9; mode_a = 1'b1; settle_a = 8'd0; start_a = 1'b1;
            e.res = 8; e.steps = 16; e.tag = "R5 binary vin=9";
            q_a.push_back(e);
            @(negedge clk);
            start_a = 1'b0;
            check(dac_a == 16'h8000, "R5 binary first code", int'(dac_a), 32768);
            wait_done_a();
        end

        // R4: saturation on 8-bit instance, plus binary there
        conv_b(1'b0, 256, 0, 255, 256, "R4 linear saturates at all-ones");
        conv_b(1'b1, 256, 0, 255, 8,   "R6 binary 8-bit full scale");
        conv_b(1'b1, 100, 1, 99,  8,   "R5 binary 8-bit vin=100");

        repeat (10) @(negedge clk);
        check(q_a.size() == 0, "R8 all 16-bit results seen", q_a.size(), 0);
        check(q_b.size() == 0, "R8 all 8-bit results seen", q_b.size(), 0);

        summary();
        $finish;
    end
endmodule